// File: doc/BRIEF.md
# Timed Delay Queue With Bypass

The block holds incoming requests for a fixed number of cycles before handing them to a bounded output FIFO. A request is accepted when its valid bit is high and the matching space exists. On acceptance it is stamped with a ready time: the value of a free-running cycle counter plus a latency parameter. Only the oldest held request is tested against the counter. Requests therefore leave in arrival order, one per cycle, once their time has come and the output FIFO has room.

A request marked as bypass class skips the hold stage and is written into the output FIFO on the cycle it is accepted. If a bypass write and a release from the hold stage fall in the same cycle, the bypass write goes first and the release waits one cycle. The consumer drains the output FIFO with a pop strobe.

Top module: `tdq_top`

## Requirements
- R1: After reset both queues are empty: `out_valid`, `dly_full` and `ds_full` are 0, and `in_ready` is 1.
- R2: A non-bypass request accepted on the edge where `cycle_i` equals c moves into the output FIFO on the first later edge where `cycle_i` has reached c+LAT, provided the FIFO has room and no bypass write is made. With both queues empty, `out_valid` is therefore first seen high LAT+1 cycles after the accepting edge.
- R3: Held requests reach `out_tag` in the order they were accepted, and tags pass through unchanged.
- R4: While the output FIFO is full, a due held request stays at the head of the hold stage and is not lost.
- R5: A bypass request is accepted only when `ds_full` is 0. It is then written to the output FIFO at once and can be seen on `out_valid`/`out_tag` one cycle later.
- R6: At most one held request enters the output FIFO per cycle. When a bypass write and a due head compete in the same cycle, the bypass tag is queued ahead of the held one.
- R7: `dly_full` is 1 when DLY_DEPTH requests are held. While it is 1, `in_ready` is 0 for a non-bypass request and that request is not taken.
- R8: The due test is computed modulo 2^CW and stays correct across counter wrap, as long as no request waits 2^(CW-1) cycles or more past its ready time.
- R9: `out_valid` is 1 whenever the output FIFO holds a tag. `out_pop` with `out_valid` removes the head. `ds_full` is 1 when DS_DEPTH tags are queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_i | input | CW | Free-running cycle counter |
| in_valid | input | 1 | Request present |
| in_bypass | input | 1 | Request skips the hold stage |
| in_tag | input | TW | Request payload |
| in_ready | output | 1 | Request is accepted this cycle if valid |
| dly_full | output | 1 | Hold stage is full |
| out_valid | output | 1 | Output FIFO holds a tag |
| out_tag | output | TW | Tag at the head of the output FIFO |
| out_pop | input | 1 | Consumer removes the head tag |
| ds_full | output | 1 | Output FIFO is full |

## Verification
A bypass write and the release of a due held request can both target the output FIFO on the same edge. The bench provokes this by timing a bypass request to arrive exactly LAT cycles after a held one, with the consumer stalled. It then reads the FIFO and expects the bypass tag first and the held tag second. A cycle-by-cycle queue model also meets this case many times in the random phase, where a backed-up output FIFO makes due heads and bypass writes pile up together.

// File: rtl/tdq_pkg.sv
package tdq_pkg;
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_BYPASS = 2'd1,
        SRC_HELD   = 2'd2
    } ds_src_e;
endpackage

// File: rtl/tdq_fifo.sv
module tdq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CNTW-1:0]         cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mem[st_q.wp] = wr_data;
            st_d.wp = ptr_inc(st_q.wp);
        end
        if (rd_en) begin
            st_d.rp = ptr_inc(st_q.rp);
        end
        st_d.cnt = st_q.cnt + CNTW'(wr_en) - CNTW'(rd_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.mem[st_q.rp];
    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt == CNTW'(DEPTH));

    // R7 / R9: the parent never writes past capacity
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en) |-> !full);

    // R9: reads only from a non-empty queue
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);

    // R6: occupancy moves by at most one entry per cycle
    a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_en) |=> $stable(st_q.cnt));
endmodule

// File: rtl/tdq_due.sv
module tdq_due #(
    parameter int CW = 16
) (
    input  logic          valid,
    input  logic [CW-1:0] now,
    input  logic [CW-1:0] ready_at,
    output logic          due
);
    logic [CW-1:0] elapsed;

    // Modular difference: non-negative (top bit clear) means the time has come
    always_comb begin
        elapsed = now - ready_at;
        due     = valid && !elapsed[CW-1];
    end
endmodule

// File: rtl/tdq_top.sv
module tdq_top #(
    parameter int TW        = 8,
    parameter int CW        = 16,
    parameter int LAT       = 4,
    parameter int DLY_DEPTH = 4,
    parameter int DS_DEPTH  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cycle_i,
    input  logic          in_valid,
    input  logic          in_bypass,
    input  logic [TW-1:0] in_tag,
    output logic          in_ready,
    output logic          dly_full,
    output logic          out_valid,
    output logic [TW-1:0] out_tag,
    input  logic          out_pop,
    output logic          ds_full
);
    import tdq_pkg::*;

    localparam logic [CW-1:0] LAT_V = CW'(LAT);
    localparam int            EW    = TW + CW;

    typedef struct packed {
        logic [TW-1:0] tag;
        logic [CW-1:0] ready_at;
    } held_t;

    held_t   push_ent, head_ent;
    logic    dly_empty, dly_valid, head_due;
    logic    byp_push, dly_push, dly_pop;
    logic    ds_wr, ds_rd, ds_empty;
    logic [TW-1:0] ds_wdata;
    ds_src_e src;

    // Acceptance and routing
    always_comb begin
        byp_push  = in_valid &&  in_bypass && !ds_full;
        dly_push  = in_valid && !in_bypass && !dly_full;
        in_ready  = in_bypass ? !ds_full : !dly_full;
        dly_valid = !dly_empty;
        push_ent.tag      = in_tag;
        push_ent.ready_at = cycle_i + LAT_V;
        dly_pop   = head_due && !ds_full && !byp_push;
        if (byp_push)     src = SRC_BYPASS;
        else if (dly_pop) src = SRC_HELD;
        else              src = SRC_NONE;
        ds_wr     = (src != SRC_NONE);
        ds_wdata  = (src == SRC_BYPASS) ? in_tag : head_ent.tag;
        ds_rd     = out_pop && !ds_empty;
        out_valid = !ds_empty;
    end

    tdq_fifo #(.W(EW), .DEPTH(DLY_DEPTH)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dly_push),
        .wr_data (push_ent),
        .rd_en   (dly_pop),
        .rd_data (head_ent),
        .empty   (dly_empty),
        .full    (dly_full)
    );

    tdq_due #(.CW(CW)) u_due (
        .valid    (dly_valid),
        .now      (cycle_i),
        .ready_at (head_ent.ready_at),
        .due      (head_due)
    );

    tdq_fifo #(.W(TW), .DEPTH(DS_DEPTH)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ds_wr),
        .wr_data (ds_wdata),
        .rd_en   (ds_rd),
        .rd_data (out_tag),
        .empty   (ds_empty),
        .full    (ds_full)
    );

    // R5: an accepted bypass request is visible at the output next cycle
    a_r5_bypass_lands: assert property (@(posedge clk) disable iff (!rst_n)
        byp_push |=> out_valid);

    // R4: a head that does not leave keeps its place and contents
    a_r4_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_valid && !dly_pop) |=> (dly_valid && $stable(head_ent)));

    // R7: a full hold stage refuses non-bypass input
    a_r7_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_full && !in_bypass) |-> !in_ready);
endmodule

// File: tb/tdq_top_tb.sv
module tdq_top_tb;
    localparam int TW = 8, CW = 8, LAT = 5, DLY = 4, DS = 3;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [CW-1:0] cyc = 8'hFB;
    logic          in_valid = 0, in_bypass = 0, out_pop = 1;
    logic [TW-1:0] in_tag = 0;
    logic          in_ready, dly_full, out_valid, ds_full;
    logic [TW-1:0] out_tag;

    int checks = 0, errors = 0;
    bit done = 0;

    int          m_dtag[$];
    logic [7:0]  m_drdy[$];
    int          m_ds[$];

    always #2 clk = ~clk;

    tdq_top #(.TW(TW), .CW(CW), .LAT(LAT), .DLY_DEPTH(DLY), .DS_DEPTH(DS)) u_dut (
        .clk(clk), .rst_n(rst_n), .cycle_i(cyc), .in_valid(in_valid),
        .in_bypass(in_bypass), .in_tag(in_tag), .in_ready(in_ready),
        .dly_full(dly_full), .out_valid(out_valid), .out_tag(out_tag),
        .out_pop(out_pop), .ds_full(ds_full)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1'b1;

    // Reference model: plain queues, updated on each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_dtag.delete(); m_drdy.delete(); m_ds.delete();
        end else begin
            bit bp, dp, due, pop_h, pop_o;
            logic [7:0] el;
            bp = in_valid && in_bypass && (m_ds.size() < DS);
            dp = in_valid && !in_bypass && (m_dtag.size() < DLY);
            due = 0;
            if (m_dtag.size() > 0) begin
                el = cyc - m_drdy[0];
                due = (el < 8'd128);
            end
            pop_h = due && (m_ds.size() < DS) && !bp;
            pop_o = out_pop && (m_ds.size() > 0);
            if (pop_o) void'(m_ds.pop_front());
            if (bp) m_ds.push_back(int'(in_tag));
            if (pop_h) begin
                m_ds.push_back(m_dtag.pop_front());
                void'(m_drdy.pop_front());
            end
            if (dp) begin
                m_dtag.push_back(int'(in_tag));
                m_drdy.push_back(cyc + 8'(LAT));
            end
        end
    end

    // Compare on every cycle, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9 out_valid", int'(out_valid), int'(m_ds.size() > 0));
            if (m_ds.size() > 0) chk("R3 out_tag order", int'(out_tag), m_ds[0]);
            chk("R7 dly_full", int'(dly_full), int'(m_dtag.size() == DLY));
            chk("R4 ds_full", int'(ds_full), int'(m_ds.size() == DS));
            if (in_bypass) chk("R5 in_ready bypass", int'(in_ready), int'(m_ds.size() < DS));
            else           chk("R7 in_ready held", int'(in_ready), int'(m_dtag.size() < DLY));
        end
    end

    task automatic send(input bit byp, input logic [7:0] t);
        in_valid = 1; in_bypass = byp; in_tag = t;
        @(posedge clk); #1;
        in_valid = 0; in_bypass = 0;
    endtask

    task automatic measure(input bit byp, input logic [7:0] t, input int exp, input string req);
        int n = 0;
        send(byp, t);
        while (n < 50) begin
            @(negedge clk); n++;
            if (out_valid) break;
        end
        chk(req, n, exp);
        chk(req, int'(out_tag), int'(t));
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 in_ready", int'(in_ready), 1);
        chk("R1 dly_full", int'(dly_full), 0);
        chk("R1 ds_full", int'(ds_full), 0);
        @(posedge clk); #1;

        // R2 / R8: ready time wraps past zero
        measure(0, 8'h11, LAT + 1, "R8 wrap latency");
        repeat (3) @(posedge clk); #1;
        measure(0, 8'h22, LAT + 1, "R2 latency");
        repeat (3) @(posedge clk); #1;
        measure(1, 8'h33, 1, "R5 bypass latency");
        repeat (3) @(posedge clk); #1;

        // R6: bypass and due head meet on the same edge
        out_pop = 0;
        send(0, 8'hA1);
        repeat (LAT - 1) @(posedge clk);
        #1 send(1, 8'hB2);
        repeat (3) @(negedge clk);
        chk("R6 bypass first", int'(out_tag), 8'hB2);
        #1 out_pop = 1;
        @(negedge clk);
        out_pop = 0;
        chk("R6 held second", int'(out_tag), 8'hA1);
        out_pop = 1;
        repeat (3) @(posedge clk); #1;

        // R7: fill the hold stage with the output blocked
        out_pop = 0;
        for (int i = 0; i < DS; i++) send(1, 8'(8'h40 + i));
        for (int i = 0; i < DLY; i++) send(0, 8'(8'h50 + i));
        @(negedge clk);
        chk("R7 full flag", int'(dly_full), 1);
        in_valid = 1; in_bypass = 0; in_tag = 8'hEE;
        @(negedge clk);
        chk("R7 refused", int'(in_ready), 0);
        @(posedge clk); #1 in_valid = 0;
        // R4: heads stay while output is full, then drain in order
        repeat (LAT + 4) @(posedge clk);
        @(negedge clk);
        chk("R4 still full", int'(ds_full), 1);
        chk("R4 head kept", int'(dly_full), 1);
        #1 out_pop = 1;
        repeat (20) @(posedge clk); #1;
        chk("R3 all drained", int'(out_valid), 0);

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            in_valid  = ($urandom_range(0, 2) != 0);
            in_bypass = ($urandom_range(0, 3) == 0);
            in_tag    = 8'($urandom);
            out_pop   = ($urandom_range(0, 1) == 1);
            @(posedge clk); #1;
        end
        in_valid = 0; out_pop = 1;
        repeat (30) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule